// File: doc/BRIEF.md
# Checksummed Configuration Store Controller

This block holds a 32-byte settings image in registers that keep their contents across reset, the way a small non-volatile store would. Bytes 0 to 9 carry device settings, bytes 10 to 30 are a free user area, and byte 31 is an XOR checksum over bytes 0 to 30. A command processor reads and writes single bytes through a request/acknowledge port pair. The block decodes the settings bytes into named fields for the rest of the chip.

After every reset the controller walks the image one byte per cycle (state SCAN). If the checksum does not match, or the force-default input was high during reset, it enters RESTORE and rewrites bytes 0 to 9 with default values. It then walks bytes 0 to 30 again to rebuild the sum (RESUM) and writes byte 31 in COMMIT. Otherwise it goes straight to IDLE. Transitions: SCAN to IDLE (sum good, no force), SCAN to RESTORE (bad sum or force), RESTORE to RESUM (after byte 9), RESUM to COMMIT (after byte 30), COMMIT to IDLE. Reset returns to SCAN from any state. Host requests are served only in IDLE. A host write also updates the checksum byte in the same clock edge, as `sum ^ old ^ new`. A reset that cuts a restore short before COMMIT leaves a stale sum, and the next reset detects and repairs it.

Top module: `cfgstore_top`

## Requirements
- R1: Whenever `ready` is high, byte 31 equals the XOR of bytes 0 to 30. This holds after every accepted write, and a read of address 31 returns it.
- R2: After reset with a valid checksum and `force_dflt` low, `ready` rises 32 clock edges after reset release and stays high. The image is unchanged.
- R3: After reset with a checksum mismatch, `ready` rises 74 edges after release. At that point bytes 0 to 9 hold the defaults and byte 31 has been recomputed.
- R4: If `force_dflt` is high in the last reset cycle, the restore of R3 runs even when the sum is valid. `ready` then rises 74 edges after release.
- R5: A restore leaves bytes 10 to 30 unchanged.
- R6: The default bytes 0 to 9 are 0x00, 0x02, 0x07, 0x0F, 0x00, 0x01, 0x02, 0x02, 0x80, 0x00. Decoded, this is ID 2, channel 7, power 15, sleep length 1, wake timeout 2, baud code 2, watch mask 0x80 and features 0x00.
- R7: An accepted write stores `wr_data` at `wr_addr` and raises `wr_done` for one cycle, one edge after acceptance.
- R8: A write to byte 2 (channel) or byte 3 (transmit power) with a value above 15 stores 15.
- R9: A write to byte 31 is acknowledged but changes nothing.
- R10: While `ready` is low, no request is accepted and neither `rd_valid` nor `wr_done` rises. A request held through reset is served once `ready` is high. A read held from reset release returns `rd_valid` 33 edges after release.
- R11: An accepted read returns `rd_data` with `rd_valid` one edge later. When a read and a write are requested together, the write goes first and the read is served on the next edge with the new value.
- R12: The decoded fields are as follows. `dev_id` is {byte0, byte1} and `sleep_len` is {byte4, byte5}. `wake_tmo` is byte 6, `watch_mask` is byte 8 and `feat_bits` is byte 9. `chan` and `txpwr` are bytes 2 and 3, shown as 15 when above 15. `baud_code` is byte 7, shown as 7 when above 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_dflt | input | 1 | Request a default restore, sampled during reset |
| rd_req | input | 1 | Read request, held until `rd_valid` |
| rd_addr | input | 5 | Read byte address |
| wr_req | input | 1 | Write request, held until `wr_done` |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| wr_done | output | 1 | Write acknowledge pulse |
| ready | output | 1 | Validation finished, requests are served |
| dev_id | output | 16 | Device ID field |
| chan | output | 4 | Channel field |
| txpwr | output | 4 | Transmit power field |
| sleep_len | output | 16 | Sleep length field |
| wake_tmo | output | 8 | Wake timeout field |
| baud_code | output | 3 | Serial rate code field |
| watch_mask | output | 8 | Watched-input mask field |
| feat_bits | output | 8 | Feature bits field |

## Verification
`ready` is due exactly 32 edges after reset release on a clean image and 74 edges after it on a restore. The bench counts falling edges from release to measure this. Reads and writes complete one edge after acceptance, so each transfer is timed from the falling edge where its request is raised and checked at the next falling edge. A read queued across reset must surface at edge 33. The decoded fields follow the image combinationally, so they are sampled on the falling edge after the acknowledge. A reset issued 50 edges into a forced restore, inside RESUM, produces the stale-sum case for the mismatch path.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;

    localparam int unsigned CS_BYTES     = 32;
    localparam int unsigned CS_W         = 8;
    localparam int unsigned CS_SET_BYTES = 10;

    // settings byte positions decoded by the field logic
    localparam int unsigned CS_ID_HI     = 0;
    localparam int unsigned CS_ID_LO     = 1;
    localparam int unsigned CS_CHAN_ADDR = 2;
    localparam int unsigned CS_PWR_ADDR  = 3;
    localparam int unsigned CS_SLP_HI    = 4;
    localparam int unsigned CS_SLP_LO    = 5;
    localparam int unsigned CS_TMO_ADDR  = 6;
    localparam int unsigned CS_BAUD_ADDR = 7;
    localparam int unsigned CS_MASK_ADDR = 8;
    localparam int unsigned CS_FEAT_ADDR = 9;

    localparam int unsigned CS_NIB_MAX   = 15;
    localparam int unsigned CS_BAUD_MAX  = 7;

    typedef enum logic [2:0] {
        ST_SCAN,
        ST_RESTORE,
        ST_RESUM,
        ST_COMMIT,
        ST_IDLE
    } cs_state_e;

    function automatic logic [7:0] cs_default(input int unsigned i);
        logic [7:0] v;
        unique case (i)
            CS_ID_LO:     v = 8'h02;
            CS_CHAN_ADDR: v = 8'h07;
            CS_PWR_ADDR:  v = 8'h0F;
            CS_SLP_LO:    v = 8'h01;
            CS_TMO_ADDR:  v = 8'h02;
            CS_BAUD_ADDR: v = 8'h02;
            CS_MASK_ADDR: v = 8'h80;
            default:      v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] cs_limit(input int unsigned a, input logic [7:0] d);
        if ((a == CS_CHAN_ADDR || a == CS_PWR_ADDR) && d > 8'(CS_NIB_MAX))
            return 8'(CS_NIB_MAX);
        return d;
    endfunction

endpackage

// File: rtl/cfgstore_array.sv
module cfgstore_array
    import cfgstore_pkg::*;
#(
    parameter int unsigned BYTES = CS_BYTES,
    parameter int unsigned W     = CS_W,
    localparam int unsigned AW   = $clog2(BYTES)
)(
    input  logic              clk,
    input  logic              wr_en,
    input  logic              sum_upd,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              sum_wr,
    input  logic [W-1:0]      sum_val,
    input  logic [AW-1:0]     rd_addr,
    output logic [W-1:0]      rd_byte,
    output logic [BYTES*W-1:0] img
);

    localparam logic [AW-1:0] SUM_A = AW'(BYTES - 1);

    // contents intentionally survive reset
    logic [W-1:0] mem [BYTES];
    logic [W-1:0] stored;

    assign stored  = W'(cs_limit(32'(wr_addr), 8'(wr_data)));
    assign rd_byte = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr != SUM_A) begin
            mem[wr_addr] <= stored;
            if (sum_upd)
                mem[SUM_A] <= mem[SUM_A] ^ mem[wr_addr] ^ stored;
        end
        if (sum_wr)
            mem[SUM_A] <= sum_val;
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_img
        assign img[g*W +: W] = mem[g];
    end

endmodule

// File: rtl/cfgstore_ctrl.sv
module cfgstore_ctrl
    import cfgstore_pkg::*;
#(
    parameter int unsigned BYTES     = CS_BYTES,
    parameter int unsigned W         = CS_W,
    parameter int unsigned SET_BYTES = CS_SET_BYTES,
    localparam int unsigned AW       = $clog2(BYTES)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_dflt,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  rd_byte,
    output logic [AW-1:0] arr_addr,
    output logic          a_wr_en,
    output logic          a_sum_upd,
    output logic [AW-1:0] a_wr_addr,
    output logic [W-1:0]  a_wr_data,
    output logic          a_sum_wr,
    output logic [W-1:0]  a_sum_val,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic          wr_done,
    output logic          ready
);

    localparam logic [AW-1:0] LAST_A  = AW'(BYTES - 1);
    localparam logic [AW-1:0] PRE_A   = AW'(BYTES - 2);
    localparam logic [AW-1:0] SET_END = AW'(SET_BYTES - 1);

    cs_state_e     state, nxt;
    logic [AW-1:0] idx, idx_n;
    logic [W-1:0]  acc, acc_n;
    logic          force_q;
    logic          rd_go, wr_go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SCAN;
            idx     <= '0;
            acc     <= '0;
            force_q <= force_dflt;
        end else begin
            state <= nxt;
            idx   <= idx_n;
            acc   <= acc_n;
        end
    end

    // next state and array control
    always_comb begin
        nxt       = state;
        idx_n     = idx;
        acc_n     = acc;
        arr_addr  = idx;
        a_wr_en   = 1'b0;
        a_sum_upd = 1'b0;
        a_wr_addr = idx;
        a_wr_data = W'(cs_default(32'(idx)));
        a_sum_wr  = 1'b0;
        a_sum_val = acc;
        rd_go     = 1'b0;
        wr_go     = 1'b0;
        unique case (state)
            ST_SCAN: begin
                if (idx == LAST_A) begin
                    idx_n = '0;
                    if (force_q || acc != rd_byte) nxt = ST_RESTORE;
                    else                           nxt = ST_IDLE;
                end else begin
                    acc_n = acc ^ rd_byte;
                    idx_n = idx + 1'b1;
                end
            end
            ST_RESTORE: begin
                a_wr_en = 1'b1;
                if (idx == SET_END) begin
                    nxt   = ST_RESUM;
                    idx_n = '0;
                    acc_n = '0;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            ST_RESUM: begin
                acc_n = acc ^ rd_byte;
                if (idx == PRE_A) nxt = ST_COMMIT;
                else              idx_n = idx + 1'b1;
            end
            ST_COMMIT: begin
                a_sum_wr = 1'b1;
                nxt      = ST_IDLE;
            end
            ST_IDLE: begin
                if (wr_req) begin
                    a_wr_en   = 1'b1;
                    a_sum_upd = 1'b1;
                    a_wr_addr = wr_addr;
                    a_wr_data = wr_data;
                    wr_go     = 1'b1;
                end else if (rd_req) begin
                    arr_addr = rd_addr;
                    rd_go    = 1'b1;
                end
            end
        endcase
    end

    // host-facing outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wr_done  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            wr_done  <= wr_go;
            if (rd_go) rd_data <= rd_byte;
        end
    end

    assign ready = (state == ST_IDLE);

endmodule

// File: rtl/cfgstore_fields.sv
module cfgstore_fields
    import cfgstore_pkg::*;
#(
    parameter int unsigned SET_BYTES = CS_SET_BYTES,
    parameter int unsigned W         = CS_W
)(
    input  logic [SET_BYTES*W-1:0] set_img,
    output logic [2*W-1:0]         dev_id,
    output logic [3:0]             chan,
    output logic [3:0]             txpwr,
    output logic [2*W-1:0]         sleep_len,
    output logic [W-1:0]           wake_tmo,
    output logic [2:0]             baud_code,
    output logic [W-1:0]           watch_mask,
    output logic [W-1:0]           feat_bits
);

    logic [W-1:0] b_chan, b_pwr, b_baud;

    assign b_chan = set_img[CS_CHAN_ADDR*W +: W];
    assign b_pwr  = set_img[CS_PWR_ADDR*W +: W];
    assign b_baud = set_img[CS_BAUD_ADDR*W +: W];

    assign dev_id     = {set_img[CS_ID_HI*W +: W],  set_img[CS_ID_LO*W +: W]};
    assign sleep_len  = {set_img[CS_SLP_HI*W +: W], set_img[CS_SLP_LO*W +: W]};
    assign wake_tmo   = set_img[CS_TMO_ADDR*W +: W];
    assign watch_mask = set_img[CS_MASK_ADDR*W +: W];
    assign feat_bits  = set_img[CS_FEAT_ADDR*W +: W];

    assign chan      = (b_chan > W'(CS_NIB_MAX))  ? 4'(CS_NIB_MAX)  : b_chan[3:0];
    assign txpwr     = (b_pwr  > W'(CS_NIB_MAX))  ? 4'(CS_NIB_MAX)  : b_pwr[3:0];
    assign baud_code = (b_baud > W'(CS_BAUD_MAX)) ? 3'(CS_BAUD_MAX) : b_baud[2:0];

endmodule

// File: rtl/cfgstore_top.sv
module cfgstore_top
    import cfgstore_pkg::*;
#(
    parameter int unsigned BYTES     = CS_BYTES,
    parameter int unsigned SET_BYTES = CS_SET_BYTES,
    localparam int unsigned W        = CS_W,
    localparam int unsigned AW       = $clog2(BYTES)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_dflt,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic          wr_done,
    output logic          ready,
    output logic [15:0]   dev_id,
    output logic [3:0]    chan,
    output logic [3:0]    txpwr,
    output logic [15:0]   sleep_len,
    output logic [7:0]    wake_tmo,
    output logic [2:0]    baud_code,
    output logic [7:0]    watch_mask,
    output logic [7:0]    feat_bits
);

    logic [AW-1:0]      arr_addr, a_wr_addr;
    logic               a_wr_en, a_sum_upd, a_sum_wr;
    logic [W-1:0]       a_wr_data, a_sum_val, rd_byte;
    logic [BYTES*W-1:0] cfg_img;

    cfgstore_ctrl #(.BYTES(BYTES), .W(W), .SET_BYTES(SET_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .force_dflt(force_dflt),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_byte(rd_byte), .arr_addr(arr_addr),
        .a_wr_en(a_wr_en), .a_sum_upd(a_sum_upd),
        .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .a_sum_wr(a_sum_wr), .a_sum_val(a_sum_val),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_done(wr_done), .ready(ready)
    );

    cfgstore_array #(.BYTES(BYTES), .W(W)) u_arr (
        .clk(clk), .wr_en(a_wr_en), .sum_upd(a_sum_upd),
        .wr_addr(a_wr_addr), .wr_data(a_wr_data),
        .sum_wr(a_sum_wr), .sum_val(a_sum_val),
        .rd_addr(arr_addr), .rd_byte(rd_byte), .img(cfg_img)
    );

    cfgstore_fields #(.SET_BYTES(SET_BYTES), .W(W)) u_fld (
        .set_img(cfg_img[SET_BYTES*W-1:0]),
        .dev_id(dev_id), .chan(chan), .txpwr(txpwr),
        .sleep_len(sleep_len), .wake_tmo(wake_tmo),
        .baud_code(baud_code), .watch_mask(watch_mask),
        .feat_bits(feat_bits)
    );

endmodule

// File: rtl/cfgstore_chk.sv
module cfgstore_chk #(
    parameter int unsigned BYTES = 32,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = $clog2(BYTES)
)(
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               rd_valid,
    input logic               wr_done,
    input logic               wr_req,
    input logic [AW-1:0]      wr_addr,
    input logic [W-1:0]       wr_data,
    input logic [3:0]         chan,
    input logic [BYTES*W-1:0] img
);

    localparam logic [AW-1:0] LAST_A = AW'(BYTES - 1);
    localparam logic [AW-1:0] CHAN_A = AW'(2);

    logic [W-1:0] xsum, sum_byte;

    always_comb begin
        xsum = '0;
        for (int i = 0; i < int'(BYTES) - 1; i++) xsum ^= img[i*W +: W];
    end
    assign sum_byte = img[(BYTES-1)*W +: W];

    p_sum_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (xsum == sum_byte));

    p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_chan_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_req && wr_addr == CHAN_A && wr_data > W'(15)) |=> (chan == 4'd15));

    p_sum_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_req && wr_addr == LAST_A) |=> $stable(sum_byte));

    p_rd_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ready);

    p_wr_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ready);

    p_one_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_done));

endmodule

bind cfgstore_top cfgstore_chk #(.BYTES(BYTES), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
    .wr_done(wr_done), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan(chan), .img(cfg_img)
);

// File: tb/cfgstore_top_test.sv
`timescale 1ns/1ps
module cfgstore_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        force_dflt = 1'b1;
    logic        rd_req = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        wr_req = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_valid, wr_done, ready;
    logic [7:0]  rd_data, wake_tmo, watch_mask, feat_bits;
    logic [15:0] dev_id, sleep_len;
    logic [3:0]  chan, txpwr;
    logic [2:0]  baud_code;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [32];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    cfgstore_top uut (
        .clk(clk), .rst_n(rst_n), .force_dflt(force_dflt),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .ready(ready), .dev_id(dev_id), .chan(chan), .txpwr(txpwr),
        .sleep_len(sleep_len), .wake_tmo(wake_tmo), .baud_code(baud_code),
        .watch_mask(watch_mask), .feat_bits(feat_bits)
    );

    function automatic logic [7:0] dflt(int i);
        logic [7:0] d [10] = '{8'h00, 8'h02, 8'h07, 8'h0F, 8'h00,
                                8'h01, 8'h02, 8'h02, 8'h80, 8'h00};
        return d[i];
    endfunction

    function automatic logic [7:0] msum();
        logic [7:0] s = '0;
        for (int i = 0; i < 31; i++) s ^= model[i];
        return s;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rd_valid", 1, 0);
            end else begin
                check(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic do_reset(logic f, output int lat);
        @(negedge clk);
        rst_n = 1'b0; force_dflt = f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lat = 0;
        while (!ready && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_write(logic [4:0] a, logic [7:0] d);
        int n = 0;
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        do begin @(negedge clk); n++; end while (!wr_done && n < 50);
        wr_req = 1'b0;
        check("R7 write ack latency", n, 1);
        if (a != 5'd31)
            model[a] = ((a == 5'd2 || a == 5'd3) && d > 8'd15) ? 8'd15 : d;
        model[31] = msum();
    endtask

    task automatic do_read(logic [4:0] a, string tag);
        int n = 0;
        exp_q.push_back(model[a]); tag_q.push_back(tag);
        rd_req = 1'b1; rd_addr = a;
        do begin @(negedge clk); n++; end while (!rd_valid && n < 50);
        rd_req = 1'b0;
        check("R11 read latency", n, 1);
    endtask

    task automatic check_defaults();
        check("R6 dev_id", dev_id, 16'd2);
        check("R6 chan", chan, 4'd7);
        check("R6 txpwr", txpwr, 4'd15);
        check("R6 sleep_len", sleep_len, 16'd1);
        check("R6 wake_tmo", wake_tmo, 8'd2);
        check("R6 baud_code", baud_code, 3'd2);
        check("R6 watch_mask", watch_mask, 8'h80);
        check("R6 feat_bits", feat_bits, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int lat;
        // forced restore from power-up
        do_reset(1'b1, lat);
        check("R4 forced restore ready latency", lat, 74);
        check("reset state rd_valid/wr_done", {rd_valid, wr_done}, 2'b00);
        check_defaults();
        for (int i = 0; i < 10; i++) model[i] = dflt(i);

        // fill user area, then read everything back
        for (int i = 10; i < 31; i++) do_write(5'(i), 8'(i * 37 + 5));
        for (int i = 0; i < 32; i++) do_read(5'(i), (i == 31) ? "R1 checksum read" : "R7 readback");

        // field writes and clamping
        do_write(5'd2, 8'h23);
        check("R8 channel saturates", chan, 4'd15);
        do_write(5'd3, 8'h09);
        check("R8 power in range", txpwr, 4'd9);
        do_write(5'd3, 8'hF0);
        check("R8 power saturates", txpwr, 4'd15);
        do_write(5'd0, 8'h12); do_write(5'd1, 8'h34);
        do_write(5'd4, 8'hAB); do_write(5'd5, 8'hCD);
        do_write(5'd6, 8'h11); do_write(5'd7, 8'h05);
        do_write(5'd8, 8'h41); do_write(5'd9, 8'h60);
        check("R12 dev_id", dev_id, 16'h1234);
        check("R12 sleep_len", sleep_len, 16'hABCD);
        check("R12 wake_tmo", wake_tmo, 8'h11);
        check("R12 baud_code", baud_code, 3'd5);
        check("R12 watch_mask", watch_mask, 8'h41);
        check("R12 feat_bits", feat_bits, 8'h60);
        do_write(5'd7, 8'h3C);
        check("R12 baud saturates", baud_code, 3'd7);

        // write to checksum byte is ignored
        do_write(5'd31, 8'h5A);
        do_read(5'd31, "R9 checksum unchanged by direct write");
        do_read(5'd2, "R8 stored channel");

        // clean reset: image retained
        do_reset(1'b0, lat);
        check("R2 clean ready latency", lat, 32);
        for (int i = 0; i < 32; i++) do_read(5'(i), "R2 image retained");

        // request held from reset release is stalled
        @(negedge clk);
        rst_n = 1'b0; force_dflt = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.push_back(model[8]); tag_q.push_back("R10 stalled read data");
        rd_addr = 5'd8; rd_req = 1'b1; rst_n = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!rd_valid && lat < 100);
        rd_req = 1'b0;
        check("R10 stalled read latency", lat, 33);

        // simultaneous read and write: write first
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 5'd20; wr_data = 8'h77;
        rd_req = 1'b1; rd_addr = 5'd20;
        model[20] = 8'h77; model[31] = msum();
        @(negedge clk);
        check("R11 write served first", {wr_done, rd_valid}, 2'b10);
        wr_req = 1'b0;
        exp_q.push_back(model[20]); tag_q.push_back("R11 read after write");
        @(negedge clk);
        check("R11 read follows", rd_valid, 1'b1);
        rd_req = 1'b0;

        // forced restore cut short inside RESUM, then mismatch repair
        @(negedge clk);
        rst_n = 1'b0; force_dflt = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check("R4 not ready mid restore", ready, 1'b0);
        do_reset(1'b0, lat);
        check("R3 mismatch ready latency", lat, 74);
        for (int i = 0; i < 10; i++) model[i] = dflt(i);
        model[31] = msum();
        check_defaults();
        for (int i = 0; i < 32; i++)
            do_read(5'(i), (i >= 10 && i < 31) ? "R5 user area kept" : "R3 restored byte");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule